// File: doc/BRIEF.md
# Sideband Wire Handshake Responder

This block sits on the slave side of an enhanced serial peripheral link and answers the sideband warning wires that the master sends. It takes decoded incoming wire events for three warnings: host reset, out-of-band reset and suspend. For the two reset warnings it first asks the matching upstream request queue to flush and go quiet. It sends the acknowledge only after that queue reports idle. The suspend warning gets its acknowledge directly. Each handshake runs in its own state machine, so two or three of them can be in progress at the same time.

The block also keeps track of the boot-complete and boot-result wires that travel from slave to master. Once a boot-complete pulse is taken, both wires are latched and reported, and they stay fixed until the platform enters its fully unpowered state. All outgoing wire changes go through a single update port that holds at most one update at a time. That port also gates upstream issue on each channel using the enable bits from the slave configuration register.

Top module: `vw_hs_responder`

## Requirements
- R1: A host-reset warning drives `pc_flush_req` high. The host-reset acknowledge is launched only after `pc_queue_idle` has been seen high while flushing, and the flush request stays high until the warning drops.
- R2: An out-of-band reset warning drives `oob_flush_req` high. The out-of-band acknowledge is launched only after `oob_queue_idle` has been seen high while flushing.
- R3: A suspend warning is answered with the suspend acknowledge. No queue flush is involved.
- R4: `boot_done_wire` is set by the first `boot_done_pulse` outside G3. It stays set regardless of later pulses and is cleared only while `in_g3` is high. Pulses that arrive during G3 are ignored.
- R5: `boot_status_wire` takes the value of `boot_pass` at the accepted boot pulse, where 1 means a good and intact image. It is reported after the boot-done update and is frozen until G3.
- R6: `pc_issue_ok` and `oob_issue_ok` are high only when the channel's enable bit is set and that channel is not quiescing.
- R7: Only one outgoing update is outstanding at a time. While `upd_ready` is low, `upd_valid`, `upd_id` and `upd_level` hold steady, and each acknowledge change is exactly one update.
- R8: If a warning drops before its acknowledge has been launched, the handshake returns to idle without sending any acknowledge update.
- R9: After an acknowledge has been sent, dropping the warning sends an update with level 0 for that acknowledge. The handshake then returns to idle.
- R10: The peripheral and out-of-band handshakes run independently. One may be waiting on its queue while the other completes.
- R11: Incoming `evt_sel` codes are 0 for host-reset warning, 1 for out-of-band warning and 2 for suspend warning. Code 3 is ignored. Outgoing `upd_id` values are 0 for host-reset ack, 1 for out-of-band ack, 2 for suspend ack, 3 for boot done and 4 for boot status. When several updates wait, the lowest id is launched first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| evt_valid | input | 1 | Decoded incoming wire event strobe |
| evt_sel | input | 2 | Which warning the event concerns |
| evt_level | input | 1 | New level of that warning |
| pc_queue_idle | input | 1 | Peripheral upstream queue is empty |
| oob_queue_idle | input | 1 | Out-of-band upstream queue is empty |
| boot_done_pulse | input | 1 | Boot completion strobe |
| boot_pass | input | 1 | Boot image result with the strobe |
| in_g3 | input | 1 | Platform is in G3 |
| pc_chan_en | input | 1 | Peripheral channel enable from configuration register |
| oob_chan_en | input | 1 | Out-of-band channel enable from configuration register |
| pc_flush_req | output | 1 | Flush/quiesce request to peripheral queue |
| oob_flush_req | output | 1 | Flush/quiesce request to out-of-band queue |
| pc_issue_ok | output | 1 | Peripheral upstream issue permitted |
| oob_issue_ok | output | 1 | Out-of-band upstream issue permitted |
| host_rst_ack | output | 1 | Host-reset acknowledge wire level |
| oob_rst_ack | output | 1 | Out-of-band reset acknowledge wire level |
| susp_ack | output | 1 | Suspend acknowledge wire level |
| boot_done_wire | output | 1 | Boot-done wire level |
| boot_status_wire | output | 1 | Boot-status wire level |
| upd_valid | output | 1 | Outgoing wire update pending |
| upd_id | output | 3 | Outgoing wire identifier |
| upd_level | output | 1 | Outgoing wire level |
| upd_ready | input | 1 | Transmit side accepts the pending update |

## Verification
The hardest case to reach from the ports is an abandoned handshake. The queue has already drained and the acknowledge is waiting to launch, but the warning drops before the launch happens. On an idle transmit path the launch follows within one cycle, so that window is almost never open. The bench opens it on purpose. It holds `upd_ready` low while a boot update is stuck in the single update slot, raises and then drops the host-reset warning behind it, and releases the transmit side afterwards. It then checks that only the two boot updates come out. The same blocking technique lets three acknowledges queue up together, which shows that the lowest id is launched first.

// File: rtl/vwhs_pkg.sv
`timescale 1ns/1ps
package vwhs_pkg;
  localparam int NUM_HS   = 3;
  localparam int NUM_BOOT = 2;
  localparam int NUM_SRC  = NUM_HS + NUM_BOOT;
  localparam int ID_W     = 3;
  localparam int SEL_W    = 2;

  localparam int HS_HOST = 0;
  localparam int HS_OOB  = 1;
  localparam int HS_SUSP = 2;

  localparam logic [ID_W-1:0] UPD_HOST  = 3'd0;
  localparam logic [ID_W-1:0] UPD_OOB   = 3'd1;
  localparam logic [ID_W-1:0] UPD_SUSP  = 3'd2;
  localparam logic [ID_W-1:0] UPD_BDONE = 3'd3;
  localparam logic [ID_W-1:0] UPD_BSTAT = 3'd4;

  typedef enum logic [2:0] {
    HS_IDLE  = 3'd0,
    HS_FLUSH = 3'd1,
    HS_SEND  = 3'd2,
    HS_ACKED = 3'd3,
    HS_CLEAR = 3'd4
  } hs_state_e;

  function automatic logic sel_is_warning(input logic [SEL_W-1:0] sel);
    return int'(sel) < NUM_HS;
  endfunction
endpackage

// File: rtl/vwhs_chan.sv
`timescale 1ns/1ps
module vwhs_chan
  import vwhs_pkg::*;
#(
  parameter bit QUIESCE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic warn_i,
  input  logic queue_idle_i,
  input  logic grant_i,
  output logic flush_o,
  output logic ack_o,
  output logic req_o,
  output logic req_level_o
);
  hs_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      HS_IDLE:  if (warn_i) state_d = QUIESCE ? HS_FLUSH : HS_SEND;
      HS_FLUSH: begin
        if (!warn_i)           state_d = HS_IDLE;
        else if (queue_idle_i) state_d = HS_SEND;
      end
      HS_SEND: begin
        if (grant_i)      state_d = HS_ACKED;
        else if (!warn_i) state_d = HS_IDLE;
      end
      HS_ACKED: if (!warn_i) state_d = HS_CLEAR;
      HS_CLEAR: if (grant_i) state_d = HS_IDLE;
      default:  state_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= HS_IDLE;
    else        state_q <= state_d;
  end

  // a request is withdrawn in the same cycle the warning drops
  assign req_o       = ((state_q == HS_SEND) && warn_i) || (state_q == HS_CLEAR);
  assign req_level_o = (state_q == HS_SEND);
  assign ack_o       = (state_q == HS_ACKED) || (state_q == HS_CLEAR);
  assign flush_o     = QUIESCE && ((state_q == HS_FLUSH) || (state_q == HS_SEND) ||
                                   (state_q == HS_ACKED));

  // R1 and R2: leaving the flush wait needs a drained queue
  a_r1_send_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (QUIESCE && state_q == HS_SEND && $past(state_q) == HS_FLUSH) |-> $past(queue_idle_i));

  a_r8_ack_needs_warn: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_o) |-> $past(warn_i));

  a_r9_drop_requests_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == HS_ACKED && !warn_i) |=> (req_o && !req_level_o && ack_o));
endmodule

// File: rtl/vwhs_boot.sv
`timescale 1ns/1ps
module vwhs_boot
  import vwhs_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pulse_i,
  input  logic                pass_i,
  input  logic                g3_i,
  input  logic [NUM_BOOT-1:0] grant_i,
  output logic                done_o,
  output logic                status_o,
  output logic [NUM_BOOT-1:0] req_o,
  output logic [NUM_BOOT-1:0] lvl_o
);
  logic                done_q, stat_q;
  logic [NUM_BOOT-1:0] pend_q;
  logic                accept;

  assign accept = pulse_i && !done_q && !g3_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      stat_q <= 1'b0;
      pend_q <= '0;
    end else if (g3_i) begin
      done_q <= 1'b0;
      stat_q <= 1'b0;
      pend_q <= '0;
    end else if (accept) begin
      done_q <= 1'b1;
      stat_q <= pass_i;
      pend_q <= '1;
    end else begin
      pend_q <= pend_q & ~grant_i;
    end
  end

  assign done_o   = done_q;
  assign status_o = stat_q;
  assign req_o    = pend_q;
  assign lvl_o    = {stat_q, done_q};

  a_r4_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !g3_i) |=> done_o);

  a_r4_g3_clears: assert property (@(posedge clk) disable iff (!rst_n)
    g3_i |=> (!done_o && !status_o));

  a_r5_status_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !g3_i) |=> $stable(status_o));
endmodule

// File: rtl/vwhs_txarb.sv
`timescale 1ns/1ps
module vwhs_txarb #(
  parameter int N    = 5,
  parameter int ID_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    req_i,
  input  logic [N-1:0]    lvl_i,
  input  logic            upd_ready_i,
  output logic [N-1:0]    grant_o,
  output logic            upd_valid_o,
  output logic [ID_W-1:0] upd_id_o,
  output logic            upd_level_o
);
  function automatic logic [N-1:0] lowest_one(input logic [N-1:0] r);
    return r & (~r + N'(1));
  endfunction

  function automatic logic [ID_W-1:0] index_of(input logic [N-1:0] oh);
    logic [ID_W-1:0] idx;
    idx = '0;
    for (int i = 0; i < N; i++) if (oh[i]) idx = ID_W'(i);
    return idx;
  endfunction

  logic            valid_q, level_q;
  logic [ID_W-1:0] id_q;

  assign grant_o = valid_q ? '0 : lowest_one(req_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      id_q    <= '0;
      level_q <= 1'b0;
    end else if (|grant_o) begin
      valid_q <= 1'b1;
      id_q    <= index_of(grant_o);
      level_q <= |(grant_o & lvl_i);
    end else if (valid_q && upd_ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign upd_valid_o = valid_q;
  assign upd_id_o    = id_q;
  assign upd_level_o = level_q;

  a_r7_hold_until_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid_o && !upd_ready_i) |=> (upd_valid_o && $stable(upd_id_o) && $stable(upd_level_o)));

  a_r7_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));
endmodule

// File: rtl/vw_hs_responder.sv
`timescale 1ns/1ps
module vw_hs_responder
  import vwhs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_valid,
  input  logic [SEL_W-1:0] evt_sel,
  input  logic             evt_level,
  input  logic             pc_queue_idle,
  input  logic             oob_queue_idle,
  input  logic             boot_done_pulse,
  input  logic             boot_pass,
  input  logic             in_g3,
  input  logic             pc_chan_en,
  input  logic             oob_chan_en,
  output logic             pc_flush_req,
  output logic             oob_flush_req,
  output logic             pc_issue_ok,
  output logic             oob_issue_ok,
  output logic             host_rst_ack,
  output logic             oob_rst_ack,
  output logic             susp_ack,
  output logic             boot_done_wire,
  output logic             boot_status_wire,
  output logic             upd_valid,
  output logic [ID_W-1:0]  upd_id,
  output logic             upd_level,
  input  logic             upd_ready
);
  logic [NUM_HS-1:0]   warn_q;
  logic [NUM_HS-1:0]   q_idle, hs_flush, hs_ack, hs_req, hs_lvl, hs_grant;
  logic [NUM_BOOT-1:0] bt_req, bt_lvl, bt_grant;
  logic [NUM_SRC-1:0]  all_req, all_lvl, all_grant;

  // incoming warning levels, reserved select code ignored
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warn_q <= '0;
    else if (evt_valid && sel_is_warning(evt_sel)) warn_q[evt_sel] <= evt_level;
  end

  assign q_idle = {1'b1, oob_queue_idle, pc_queue_idle};

  for (genvar g = 0; g < NUM_HS; g++) begin : g_hs
    vwhs_chan #(.QUIESCE(g != HS_SUSP)) u_chan (
      .clk         (clk),
      .rst_n       (rst_n),
      .warn_i      (warn_q[g]),
      .queue_idle_i(q_idle[g]),
      .grant_i     (hs_grant[g]),
      .flush_o     (hs_flush[g]),
      .ack_o       (hs_ack[g]),
      .req_o       (hs_req[g]),
      .req_level_o (hs_lvl[g])
    );
  end

  vwhs_boot u_boot (
    .clk     (clk),
    .rst_n   (rst_n),
    .pulse_i (boot_done_pulse),
    .pass_i  (boot_pass),
    .g3_i    (in_g3),
    .grant_i (bt_grant),
    .done_o  (boot_done_wire),
    .status_o(boot_status_wire),
    .req_o   (bt_req),
    .lvl_o   (bt_lvl)
  );

  assign all_req  = {bt_req, hs_req};
  assign all_lvl  = {bt_lvl, hs_lvl};
  assign hs_grant = all_grant[NUM_HS-1:0];
  assign bt_grant = all_grant[NUM_SRC-1:NUM_HS];

  vwhs_txarb #(.N(NUM_SRC), .ID_W(ID_W)) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (all_req),
    .lvl_i      (all_lvl),
    .upd_ready_i(upd_ready),
    .grant_o    (all_grant),
    .upd_valid_o(upd_valid),
    .upd_id_o   (upd_id),
    .upd_level_o(upd_level)
  );

  assign pc_flush_req  = hs_flush[HS_HOST];
  assign oob_flush_req = hs_flush[HS_OOB];
  assign host_rst_ack  = hs_ack[HS_HOST];
  assign oob_rst_ack   = hs_ack[HS_OOB];
  assign susp_ack      = hs_ack[HS_SUSP];
  assign pc_issue_ok   = pc_chan_en  && !hs_flush[HS_HOST];
  assign oob_issue_ok  = oob_chan_en && !hs_flush[HS_OOB];

  a_r7_host_ack_is_update: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_rst_ack) |-> (upd_valid && upd_id == UPD_HOST && upd_level));

  a_r11_reserved_code: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !sel_is_warning(evt_sel)) |=> $stable(warn_q));

  a_r3_susp_never_flushes: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(susp_ack) |-> (upd_id == UPD_SUSP));
endmodule

// File: tb/vw_hs_responder_bench.sv
`timescale 1ns/1ps
module vw_hs_responder_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic evt_valid = 0, evt_level = 0;
  logic [1:0] evt_sel = 0;
  logic pci = 0, oobi = 0, bp = 0, bpass = 0, g3 = 0, pce = 1, oobe = 1, rdy = 1;
  logic pc_flush_req, oob_flush_req, pc_issue_ok, oob_issue_ok;
  logic host_rst_ack, oob_rst_ack, susp_ack, boot_done_wire, boot_status_wire;
  logic upd_valid, upd_level;
  logic [2:0] upd_id;

  int checks = 0, fails = 0;
  logic [3:0] log_e [16];
  int log_n = 0;

  always #10 clk = ~clk;

  vw_hs_responder u_vw_hs_responder (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_sel(evt_sel), .evt_level(evt_level),
    .pc_queue_idle(pci), .oob_queue_idle(oobi), .boot_done_pulse(bp), .boot_pass(bpass),
    .in_g3(g3), .pc_chan_en(pce), .oob_chan_en(oobe),
    .pc_flush_req(pc_flush_req), .oob_flush_req(oob_flush_req),
    .pc_issue_ok(pc_issue_ok), .oob_issue_ok(oob_issue_ok),
    .host_rst_ack(host_rst_ack), .oob_rst_ack(oob_rst_ack), .susp_ack(susp_ack),
    .boot_done_wire(boot_done_wire), .boot_status_wire(boot_status_wire),
    .upd_valid(upd_valid), .upd_id(upd_id), .upd_level(upd_level), .upd_ready(rdy)
  );

  always @(posedge clk)
    if (rst_n && upd_valid && rdy && log_n < 16) begin
      log_e[log_n] = {upd_id, upd_level};
      log_n = log_n + 1;
    end

  // {hr_ack, oob_ack, sus_ack, pc_flush, oob_flush, pc_ok, oob_ok, bdone, bstat}
  typedef struct packed {
    logic ev; logic [1:0] sel; logic lvl; logic bp; logic bpass;
    logic pci; logic oobi; logic pce; logic oobe; logic g3; logic [8:0] exp;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 9'b000_10_01_00}, // R1 wait
    '{1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 9'b100_10_01_00}, // R1 ack
    '{1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 9'b100_10_01_00}, // R6
    '{1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 9'b000_00_01_00}, // R9 R6
    '{1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 9'b000_00_11_00}, // R6
    '{1'b1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 9'b000_01_10_00}, // R2 wait
    '{1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 9'b100_11_00_00}, // R10
    '{1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 9'b100_10_01_00}, // R8
    '{1'b1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 9'b110_11_00_00}, // R2 ack
    '{1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 9'b010_01_10_00}, // R9
    '{1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 9'b000_00_11_00}, // R9
    '{1'b1, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 9'b001_00_11_00}, // R3
    '{1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 9'b000_00_11_00}, // R3
    '{1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 9'b000_00_11_11}, // R4 R5
    '{1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 9'b000_00_11_11}, // R4 sticky
    '{1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 9'b000_00_11_00}, // R4 G3
    '{1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 9'b000_00_11_00}, // R4 in G3
    '{1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 9'b000_00_11_10}, // R5 fail
    '{1'b1, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 9'b000_00_11_10}  // R11
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_evt(input logic [1:0] s, input logic l);
    evt_valid = 1; evt_sel = s; evt_level = l;
    tick(1);
    evt_valid = 0;
  endtask

  function automatic logic [8:0] snap();
    return {host_rst_ack, oob_rst_ack, susp_ack, pc_flush_req, oob_flush_req,
            pc_issue_ok, oob_issue_ok, boot_done_wire, boot_status_wire};
  endfunction

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    tick(3);
    // reset state: R4 R7
    check("R4 reset", snap(), 9'b000_00_11_00);
    check("R7 reset valid", upd_valid, 0);
    rst_n = 1;
    tick(2);

    for (int i = 0; i < NV; i++) begin
      pci = VECS[i].pci; oobi = VECS[i].oobi; pce = VECS[i].pce;
      oobe = VECS[i].oobe; g3 = VECS[i].g3;
      evt_valid = VECS[i].ev; evt_sel = VECS[i].sel; evt_level = VECS[i].lvl;
      bp = VECS[i].bp; bpass = VECS[i].bpass;
      tick(1);
      evt_valid = 0; bp = 0;
      tick(8);
      check($sformatf("row %0d", i), snap(), VECS[i].exp);
      check($sformatf("R7 idle after row %0d", i), upd_valid, 0);
    end

    // R8 with R5 order: abandoned host handshake behind a stuck update
    g3 = 1; tick(2); g3 = 0; tick(2);
    rdy = 0; log_n = 0;
    bp = 1; bpass = 1; tick(1); bp = 0;
    tick(3);
    check("R5 done update first", {upd_valid, upd_id, upd_level}, {1'b1, 3'd3, 1'b1});
    pci = 1;
    send_evt(2'd0, 1'b1);
    tick(5);
    check("R7 held while not ready", {upd_valid, upd_id, upd_level}, {1'b1, 3'd3, 1'b1});
    check("R1 flushing behind blocked ack", pc_flush_req, 1);
    send_evt(2'd0, 1'b0);
    tick(3);
    check("R8 flush dropped", pc_flush_req, 0);
    rdy = 1;
    tick(8);
    check("R8 update count", log_n, 2);
    check("R5 first entry", log_e[0], {3'd3, 1'b1});
    check("R5 second entry", log_e[1], {3'd4, 1'b1});
    check("R8 no host ack", host_rst_ack, 0);

    // R11 priority and R9 clears
    rdy = 0; log_n = 0; oobi = 1;
    send_evt(2'd0, 1'b1);
    tick(6);
    send_evt(2'd2, 1'b1);
    tick(2);
    send_evt(2'd1, 1'b1);
    tick(8);
    rdy = 1;
    tick(10);
    check("R11 count", log_n, 3);
    check("R11 first", log_e[0], {3'd0, 1'b1});
    check("R11 second lowest", log_e[1], {3'd1, 1'b1});
    check("R11 third", log_e[2], {3'd2, 1'b1});
    check("R10 all acks", {host_rst_ack, oob_rst_ack, susp_ack}, 3'b111);
    send_evt(2'd2, 1'b0);
    send_evt(2'd1, 1'b0);
    send_evt(2'd0, 1'b0);
    tick(10);
    check("R9 clear count", log_n, 6);
    check("R9 clear levels", {log_e[3][0], log_e[4][0], log_e[5][0]}, 3'b000);
    check("R9 acks low", {host_rst_ack, oob_rst_ack, susp_ack}, 3'b000);

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule